// File: doc/BRIEF.md
# Timestamp Event Capture Unit

This block is a time-synchronisation peripheral on a simple 32-bit register bus. It keeps a 32-bit counter that advances once per clock while the block is enabled. Events from several sources are stamped with that counter and queued in one event FIFO. The sources are a software push through the bus, up to four hardware pins, counter wrap, counter half-wrap, and Ethernet receive and transmit strobes.

Software polls or takes an interrupt, then reads the oldest queued event as two words. The low word holds the timestamp. The high word holds the source port, the event kind, the PTP message type and the PTP sequence number. A single-bit write then pops that entry. A raw pending flag and a masked pending flag report that events are queued, and the masked flag drives the `irq` output. If events are lost, a sticky flag is raised.

Top module: `tsc_capture_unit`

## Requirements
- R1: After reset the control word reads 0, both pending flags read 0, `irq` and `ovf_flag` are 0, and word 0 reads the identification value {ID_CODE[15:0], ID_RTL[4:0], ID_MAJ[2:0], ID_MIN[7:0]} (default 32'h7A3C_1105).
- R2: While control bit 0 is 1 the counter increments by one per clock. While it is 0 the counter holds. Writing 1 to bit 0 of word 5 copies the word 4 value into the counter, and this takes precedence over the increment.
- R3: Writing 1 to bit 0 of word 3 queues an event of kind 0, port 0, with the counter value present in the write cycle as its timestamp.
- R4: Pin k (k = 1..NPIN, `hw_pin[k-1]`) is enabled by control bit 7+k. Each rising edge passes a two-flop synchroniser. Two clocks after the first synchroniser stage samples the high level, the edge queues kind 3 with port k. A pin whose enable bit is 0 queues nothing.
- R5: When the counter steps from all ones to zero, kind 1 is queued with timestamp 0. When it steps from 32'h7FFF_FFFF to 32'h8000_0000, kind 2 is queued with timestamp 32'h8000_0000. A load never creates either event.
- R6: `eth_rx_vld` queues kind 4 and `eth_tx_vld` queues kind 5. Each takes its port, message type and sequence number from the `eth_*` fields and its timestamp from the counter in that cycle.
- R7: Word 13 reads the head timestamp. Word 14 reads {3'b0, port[4:0], kind[3:0], msg[3:0], seq[15:0]}.
- R8: The FIFO holds DEPTH (16) entries and returns them oldest first. Writing 1 to bit 0 of word 12 discards the head. A pop on an empty FIFO does nothing. Words 13 and 14 read 0 while the FIFO is empty.
- R9: Only one event is queued per cycle, in this priority order: wrap, half-wrap, software push, pin 1..NPIN, receive, transmit. An event that arrives while the FIFO is full is dropped, and so is any lower-priority event in a busy cycle. Either loss sets `ovf_flag`, which stays set until reset.
- R10: Word 8 bit 0 (raw) is 1 when the FIFO is non-empty or control bit 1 is set. Word 9 bit 0 (masked) equals raw AND word 10 bit 0. `irq` equals the masked flag.
- R11: While control bit 0 is 0, no source queues an event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 4 | Word address of register access |
| bus_wen | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` |
| hw_pin | input | NPIN | Asynchronous hardware push pins |
| eth_rx_vld | input | 1 | Ethernet receive timestamp strobe |
| eth_tx_vld | input | 1 | Ethernet transmit timestamp strobe |
| eth_port | input | 5 | Port number for the Ethernet strobe |
| eth_msg | input | 4 | PTP message type for the Ethernet strobe |
| eth_seq | input | 16 | PTP sequence number for the Ethernet strobe |
| irq | output | 1 | Masked pending interrupt |
| ovf_flag | output | 1 | Sticky lost-event flag |

## Verification
The counter cannot be read directly. A counter that drifts, runs while disabled or loads late therefore shows up only in the timestamp of the next captured event, so every push is checked against an independently tracked count. A wrong FIFO pointer or count shows as entries out of order, duplicated or missing when the queue is drained, or as a pending flag stuck high or low on the next status read. Faults in the arbiter or the drop logic appear as a missing or extra entry, and as `ovf_flag` on the cycle after the loss.

// File: rtl/tsc_pkg.sv
package tsc_pkg;

    localparam int TS_W          = 32;
    localparam int CTRL_EN_BIT   = 0;
    localparam int CTRL_TEST_BIT = 1;
    localparam int CTRL_PIN_LSB  = 8;

    typedef enum logic [3:0] {
        EV_SWPUSH = 4'd0,
        EV_WRAP   = 4'd1,
        EV_HALF   = 4'd2,
        EV_PIN    = 4'd3,
        EV_RX     = 4'd4,
        EV_TX     = 4'd5
    } ev_kind_e;

    typedef enum logic [3:0] {
        RA_ID     = 4'd0,
        RA_CTRL   = 4'd1,
        RA_CLKSEL = 4'd2,
        RA_PUSH   = 4'd3,
        RA_LDVAL  = 4'd4,
        RA_LDEN   = 4'd5,
        RA_RAW    = 4'd8,
        RA_MASK   = 4'd9,
        RA_IEN    = 4'd10,
        RA_POP    = 4'd12,
        RA_EVLO   = 4'd13,
        RA_EVHI   = 4'd14
    } reg_addr_e;

    typedef struct packed {
        logic [4:0]      port;
        ev_kind_e        kind;
        logic [3:0]      msg;
        logic [15:0]     seq;
        logic [TS_W-1:0] stamp;
    } ev_rec_t;

    function automatic logic [31:0] pack_hi(input ev_rec_t r);
        return {3'b000, r.port, r.kind, r.msg, r.seq};
    endfunction

endpackage

// File: rtl/tsc_counter.sv
module tsc_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         run,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] cnt,
    output logic         wrap_evt,
    output logic         half_evt
);
    localparam logic [W-1:0] ALL_ONES = '1;
    localparam logic [W-1:0] HALF_M1  = {1'b0, {(W-1){1'b1}}};

    logic stepping;
    assign stepping = run && !load;
    assign wrap_evt = stepping && (cnt == ALL_ONES);
    assign half_evt = stepping && (cnt == HALF_M1);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (run) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/tsc_pin_edge.sv
module tsc_pin_edge #(
    parameter int NPIN = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NPIN-1:0] pin_async,
    output logic [NPIN-1:0] rise
);
    for (genvar g = 0; g < NPIN; g++) begin : g_pin
        logic [2:0] sh;
        always_ff @(posedge clk) begin
            if (rst) begin
                sh <= '0;
            end else begin
                sh <= {sh[1:0], pin_async[g]};
            end
        end
        assign rise[g] = sh[1] & ~sh[2];
    end
endmodule

// File: rtl/tsc_evt_fifo.sv
module tsc_evt_fifo #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 61,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic [CNT_W-1:0] count,
    output logic             empty,
    output logic             full
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wp, rp;
    logic             do_wr, do_pop;

    assign empty  = (count == '0);
    assign full   = (count == CNT_W'(DEPTH));
    assign do_wr  = wr_en && !full;
    assign do_pop = pop && !empty;
    assign head   = mem[rp];

    always_ff @(posedge clk) begin
        if (do_wr) begin
            mem[wp] <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (do_wr) begin
                wp <= (wp == LAST) ? '0 : wp + 1'b1;
            end
            if (do_pop) begin
                rp <= (rp == LAST) ? '0 : rp + 1'b1;
            end
            case ({do_wr, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/tsc_capture_unit.sv
module tsc_capture_unit
    import tsc_pkg::*;
#(
    parameter int          NPIN     = 4,
    parameter int          DEPTH    = 16,
    parameter int          CLKSEL_W = 5,
    parameter logic [15:0] ID_CODE  = 16'h7A3C,
    parameter logic [4:0]  ID_RTL   = 5'd2,
    parameter logic [2:0]  ID_MAJ   = 3'd1,
    parameter logic [7:0]  ID_MIN   = 8'h05
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [3:0]      bus_addr,
    input  logic            bus_wen,
    input  logic [31:0]     bus_wdata,
    output logic [31:0]     bus_rdata,
    input  logic [NPIN-1:0] hw_pin,
    input  logic            eth_rx_vld,
    input  logic            eth_tx_vld,
    input  logic [4:0]      eth_port,
    input  logic [3:0]      eth_msg,
    input  logic [15:0]     eth_seq,
    output logic            irq,
    output logic            ovf_flag
);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int REC_W = $bits(ev_rec_t);

    // register state
    logic                en_q, test_q, ien_q, ovf_q;
    logic [NPIN-1:0]     pin_en_q;
    logic [CLKSEL_W-1:0] clksel_q;
    logic [TS_W-1:0]     ldval_q;

    // write strobes
    logic wr_ctrl, wr_clksel, wr_ldval, wr_ien;
    logic sw_stb, ld_stb, pop_stb;

    assign wr_ctrl   = bus_wen && (bus_addr == RA_CTRL);
    assign wr_clksel = bus_wen && (bus_addr == RA_CLKSEL);
    assign wr_ldval  = bus_wen && (bus_addr == RA_LDVAL);
    assign wr_ien    = bus_wen && (bus_addr == RA_IEN);
    assign sw_stb    = bus_wen && (bus_addr == RA_PUSH) && bus_wdata[0];
    assign ld_stb    = bus_wen && (bus_addr == RA_LDEN) && bus_wdata[0];
    assign pop_stb   = bus_wen && (bus_addr == RA_POP)  && bus_wdata[0];

    // counter
    logic [TS_W-1:0] cnt_q;
    logic            wrap_evt, half_evt;

    tsc_counter #(.W(TS_W)) u_ctr (
        .clk      (clk),
        .rst      (rst),
        .run      (en_q),
        .load     (ld_stb),
        .load_val (ldval_q),
        .cnt      (cnt_q),
        .wrap_evt (wrap_evt),
        .half_evt (half_evt)
    );

    // hardware pins
    logic [NPIN-1:0] pin_rise, pin_ok;

    tsc_pin_edge #(.NPIN(NPIN)) u_pins (
        .clk       (clk),
        .rst       (rst),
        .pin_async (hw_pin),
        .rise      (pin_rise)
    );

    assign pin_ok = pin_rise & pin_en_q & {NPIN{en_q}};

    // source arbitration: later assignments win
    logic    sw_ok, rx_ok, tx_ok, sel_vld, multi, lost_evt;
    ev_rec_t sel_rec;

    assign sw_ok = en_q && sw_stb;
    assign rx_ok = en_q && eth_rx_vld;
    assign tx_ok = en_q && eth_tx_vld;
    assign multi = $countones({tx_ok, rx_ok, pin_ok, sw_ok, half_evt, wrap_evt}) > 1;

    always_comb begin
        sel_vld = 1'b0;
        sel_rec = '0;
        if (tx_ok) begin
            sel_vld = 1'b1;
            sel_rec = '{port: eth_port, kind: EV_TX, msg: eth_msg, seq: eth_seq, stamp: cnt_q};
        end
        if (rx_ok) begin
            sel_vld = 1'b1;
            sel_rec = '{port: eth_port, kind: EV_RX, msg: eth_msg, seq: eth_seq, stamp: cnt_q};
        end
        for (int i = NPIN - 1; i >= 0; i--) begin
            if (pin_ok[i]) begin
                sel_vld = 1'b1;
                sel_rec = '{port: 5'(i + 1), kind: EV_PIN, msg: 4'd0, seq: 16'd0, stamp: cnt_q};
            end
        end
        if (sw_ok) begin
            sel_vld = 1'b1;
            sel_rec = '{port: 5'd0, kind: EV_SWPUSH, msg: 4'd0, seq: 16'd0, stamp: cnt_q};
        end
        if (half_evt) begin
            sel_vld = 1'b1;
            sel_rec = '{port: 5'd0, kind: EV_HALF, msg: 4'd0, seq: 16'd0,
                        stamp: {1'b1, {(TS_W-1){1'b0}}}};
        end
        if (wrap_evt) begin
            sel_vld = 1'b1;
            sel_rec = '{port: 5'd0, kind: EV_WRAP, msg: 4'd0, seq: 16'd0, stamp: '0};
        end
    end

    // event queue
    ev_rec_t          head_rec;
    logic [CNT_W-1:0] fifo_cnt;
    logic             fifo_empty, fifo_full, fifo_wr;

    assign fifo_wr  = sel_vld && !fifo_full;
    assign lost_evt = (sel_vld && fifo_full) || multi;

    tsc_evt_fifo #(.DEPTH(DEPTH), .WIDTH(REC_W)) u_fifo (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (fifo_wr),
        .wr_data (sel_rec),
        .pop     (pop_stb),
        .head    (head_rec),
        .count   (fifo_cnt),
        .empty   (fifo_empty),
        .full    (fifo_full)
    );

    // register file
    always_ff @(posedge clk) begin
        if (rst) begin
            en_q     <= 1'b0;
            test_q   <= 1'b0;
            pin_en_q <= '0;
            clksel_q <= '0;
            ldval_q  <= '0;
            ien_q    <= 1'b0;
            ovf_q    <= 1'b0;
        end else begin
            if (wr_ctrl) begin
                en_q     <= bus_wdata[CTRL_EN_BIT];
                test_q   <= bus_wdata[CTRL_TEST_BIT];
                pin_en_q <= bus_wdata[CTRL_PIN_LSB +: NPIN];
            end
            if (wr_clksel) clksel_q <= bus_wdata[CLKSEL_W-1:0];
            if (wr_ldval)  ldval_q  <= bus_wdata;
            if (wr_ien)    ien_q    <= bus_wdata[0];
            if (lost_evt)  ovf_q    <= 1'b1;
        end
    end

    // pending flags
    logic raw_pend, mask_pend;
    assign raw_pend  = !fifo_empty || test_q;
    assign mask_pend = raw_pend && ien_q;
    assign irq       = mask_pend;
    assign ovf_flag  = ovf_q;

    // read mux
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            RA_ID:     bus_rdata = {ID_CODE, ID_RTL, ID_MAJ, ID_MIN};
            RA_CTRL: begin
                bus_rdata[CTRL_EN_BIT]            = en_q;
                bus_rdata[CTRL_TEST_BIT]          = test_q;
                bus_rdata[CTRL_PIN_LSB +: NPIN]   = pin_en_q;
            end
            RA_CLKSEL: bus_rdata[CLKSEL_W-1:0] = clksel_q;
            RA_LDVAL:  bus_rdata = ldval_q;
            RA_RAW:    bus_rdata[0] = raw_pend;
            RA_MASK:   bus_rdata[0] = mask_pend;
            RA_IEN:    bus_rdata[0] = ien_q;
            RA_EVLO:   if (!fifo_empty) bus_rdata = head_rec.stamp;
            RA_EVHI:   if (!fifo_empty) bus_rdata = pack_hi(head_rec);
            default:   bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/tsc_checker.sv
module tsc_checker #(
    parameter int DEPTH = 16,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst,
    input logic             en,
    input logic             ien,
    input logic             load_stb,
    input logic [31:0]      cnt,
    input logic [CNT_W-1:0] fifo_cnt,
    input logic [3:0]       bus_addr,
    input logic [31:0]      bus_rdata,
    input logic             irq,
    input logic             ovf_flag
);
    assert_ctr_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (!en && !load_stb) |=> (cnt == $past(cnt)));

    assert_ctr_step_R2: assert property (@(posedge clk) disable iff (rst)
        (en && !load_stb) |=> (cnt == $past(cnt) + 32'd1));

    assert_fifo_bound_R8: assert property (@(posedge clk) disable iff (rst)
        fifo_cnt <= CNT_W'(DEPTH));

    assert_empty_read_R8: assert property (@(posedge clk) disable iff (rst)
        (fifo_cnt == '0 && (bus_addr == 4'd13 || bus_addr == 4'd14)) |-> (bus_rdata == 32'd0));

    assert_ovf_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        ovf_flag |=> ovf_flag);

    assert_irq_gated_R10: assert property (@(posedge clk) disable iff (rst)
        irq |-> ien);

    assert_no_capture_R11: assert property (@(posedge clk) disable iff (rst)
        !en |=> (fifo_cnt <= $past(fifo_cnt)));
endmodule

bind tsc_capture_unit tsc_checker #(.DEPTH(DEPTH)) u_tsc_checker (
    .clk       (clk),
    .rst       (rst),
    .en        (en_q),
    .ien       (ien_q),
    .load_stb  (ld_stb),
    .cnt       (cnt_q),
    .fifo_cnt  (fifo_cnt),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .irq       (irq),
    .ovf_flag  (ovf_flag)
);

// File: tb/test_tsc_capture_unit.sv
module test_tsc_capture_unit;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] ID_EXP = 32'h7A3C_1105;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  bus_addr = '0;
    logic        bus_wen = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  hw_pin = '0;
    logic        eth_rx_vld = 1'b0, eth_tx_vld = 1'b0;
    logic [4:0]  eth_port = '0;
    logic [3:0]  eth_msg = '0;
    logic [15:0] eth_seq = '0;
    logic        irq, ovf_flag;

    tsc_capture_unit i_tsc_capture_unit (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wen(bus_wen),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .hw_pin(hw_pin),
        .eth_rx_vld(eth_rx_vld), .eth_tx_vld(eth_tx_vld), .eth_port(eth_port),
        .eth_msg(eth_msg), .eth_seq(eth_seq), .irq(irq), .ovf_flag(ovf_flag)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    // independent counter model from R2
    logic [31:0] model_cnt = '0;
    logic        model_en = 1'b0;
    logic [31:0] ld_shadow = '0;
    always @(posedge clk) begin
        if (rst) begin
            model_cnt <= '0;
            model_en  <= 1'b0;
        end else begin
            if (bus_wen && bus_addr == 4'd1) model_en <= bus_wdata[0];
            if (bus_wen && bus_addr == 4'd5 && bus_wdata[0]) model_cnt <= ld_shadow;
            else if (model_en) model_cnt <= model_cnt + 32'd1;
        end
    end

    typedef struct { logic [31:0] lo; logic [31:0] hi; } exp_t;
    exp_t expq[$];

    function automatic logic [31:0] mk_hi(input logic [4:0] port, input logic [3:0] kind,
                                          input logic [3:0] msg, input logic [15:0] seq);
        return {3'b000, port, kind, msg, seq};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wen = 1'b1;
        if (a == 4'd4) ld_shadow = d;
        @(negedge clk);
        bus_wen = 1'b0; bus_addr = 4'd0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] v);
        @(negedge clk);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    // driver: software push, expected entry queued when it should be kept
    task automatic drv_push(input bit keep);
        @(negedge clk);
        bus_addr = 4'd3; bus_wdata = 32'd1; bus_wen = 1'b1;
        if (keep) expq.push_back('{lo: model_cnt, hi: mk_hi(5'd0, 4'd0, 4'd0, 16'd0)});
        @(negedge clk);
        bus_wen = 1'b0; bus_addr = 4'd0; bus_wdata = '0;
    endtask

    task automatic drv_eth(input bit tx, input logic [4:0] p, input logic [3:0] m,
                           input logic [15:0] s);
        @(negedge clk);
        eth_port = p; eth_msg = m; eth_seq = s;
        if (tx) eth_tx_vld = 1'b1; else eth_rx_vld = 1'b1;
        expq.push_back('{lo: model_cnt, hi: mk_hi(p, tx ? 4'd5 : 4'd4, m, s)});
        @(negedge clk);
        eth_tx_vld = 1'b0; eth_rx_vld = 1'b0;
    endtask

    task automatic drv_pin(input int idx, input bit keep);
        @(negedge clk);
        hw_pin[idx] = 1'b1;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        if (keep) expq.push_back('{lo: model_cnt, hi: mk_hi(5'(idx + 1), 4'd3, 4'd0, 16'd0)});
        @(negedge clk);
        hw_pin[idx] = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    // monitor: drains the FIFO and compares against the scoreboard
    task automatic drain(input string req);
        logic [31:0] raw, lo, hi;
        for (int k = 0; k < 40; k++) begin
            rd(4'd8, raw);
            if (raw[0] == 1'b0) break;
            rd(4'd13, lo);
            rd(4'd14, hi);
            if (expq.size() == 0) begin
                check({req, " unexpected entry lo"}, lo, 32'hxxxx_xxxx);
            end else begin
                check({req, " timestamp"}, lo, expq[0].lo);
                check({req, " high word"}, hi, expq[0].hi);
                void'(expq.pop_front());
            end
            wr(4'd12, 32'd1);
        end
        check({req, " missing entries"}, 32'(expq.size()), 32'd0);
        expq.delete();
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(4'd0, v);  check("R1 id", v, ID_EXP);
        rd(4'd1, v);  check("R1 ctrl", v, 32'd0);
        rd(4'd8, v);  check("R1 raw", v, 32'd0);
        check("R1 irq", {31'd0, irq}, 32'd0);
        check("R1 ovf", {31'd0, ovf_flag}, 32'd0);

        // R11 disabled: nothing captured; R8 empty reads and empty pop
        drv_push(1'b0);
        @(negedge clk); eth_rx_vld = 1'b1; @(negedge clk); eth_rx_vld = 1'b0;
        rd(4'd8, v);  check("R11 no capture when disabled", v, 32'd0);
        rd(4'd13, v); check("R8 empty low reads zero", v, 32'd0);
        rd(4'd14, v); check("R8 empty high reads zero", v, 32'd0);
        wr(4'd12, 32'd1);

        // R2 load and run, R3 pushes in order (R8)
        wr(4'd4, 32'h0000_1000);
        wr(4'd5, 32'd1);
        wr(4'd1, 32'h0000_0701);
        drv_push(1'b1);
        drv_push(1'b1);
        repeat (5) @(negedge clk);
        drv_push(1'b1);
        drain("R3 R8 push order");

        // R2 hold while disabled, load while disabled
        wr(4'd1, 32'h0000_0700);
        repeat (10) @(negedge clk);
        wr(4'd4, 32'h0ABC_0000);
        wr(4'd5, 32'd1);
        repeat (6) @(negedge clk);
        wr(4'd1, 32'h0000_0701);
        drv_push(1'b1);
        drain("R2 hold and load");

        // R6 R7 Ethernet events
        drv_eth(1'b0, 5'd2, 4'h3, 16'hBEEF);
        drv_eth(1'b1, 5'd17, 4'hC, 16'h1234);
        drain("R6 R7 ethernet");

        // R4 pins: 1 and 3 enabled, 4 disabled
        drv_pin(0, 1'b1);
        drv_pin(2, 1'b1);
        drv_pin(3, 1'b0);
        drain("R4 pins");

        // R5 wrap and half wrap
        wr(4'd4, 32'hFFFF_FFFD);
        wr(4'd5, 32'd1);
        expq.push_back('{lo: 32'd0, hi: mk_hi(5'd0, 4'd1, 4'd0, 16'd0)});
        repeat (6) @(negedge clk);
        drain("R5 wrap");
        wr(4'd4, 32'h7FFF_FFFD);
        wr(4'd5, 32'd1);
        expq.push_back('{lo: 32'h8000_0000, hi: mk_hi(5'd0, 4'd2, 4'd0, 16'd0)});
        repeat (6) @(negedge clk);
        drain("R5 half wrap");

        // R10 interrupt masking and test bit
        drv_push(1'b1);
        rd(4'd8, v);  check("R10 raw pending", v, 32'd1);
        rd(4'd9, v);  check("R10 masked off", v, 32'd0);
        check("R10 irq off", {31'd0, irq}, 32'd0);
        wr(4'd10, 32'd1);
        rd(4'd9, v);  check("R10 masked on", v, 32'd1);
        check("R10 irq on", {31'd0, irq}, 32'd1);
        drain("R10 drain");
        check("R10 irq after drain", {31'd0, irq}, 32'd0);
        wr(4'd1, 32'h0000_0703);
        rd(4'd8, v);  check("R10 test bit raw", v, 32'd1);
        check("R10 test bit irq", {31'd0, irq}, 32'd1);
        wr(4'd1, 32'h0000_0701);
        check("R10 test bit cleared", {31'd0, irq}, 32'd0);

        // R9 collision: push wins over receive
        check("R9 no loss yet", {31'd0, ovf_flag}, 32'd0);
        @(negedge clk);
        bus_addr = 4'd3; bus_wdata = 32'd1; bus_wen = 1'b1;
        eth_rx_vld = 1'b1; eth_port = 5'd1; eth_msg = 4'd1; eth_seq = 16'd7;
        expq.push_back('{lo: model_cnt, hi: mk_hi(5'd0, 4'd0, 4'd0, 16'd0)});
        @(negedge clk);
        bus_wen = 1'b0; bus_addr = 4'd0; eth_rx_vld = 1'b0;
        check("R9 ovf after collision", {31'd0, ovf_flag}, 32'd1);
        drain("R9 collision");

        // R8 R9 full FIFO drops the 17th event
        for (int k = 0; k < 16; k++) drv_push(1'b1);
        drv_push(1'b0);
        drain("R8 R9 full queue");
        check("R9 ovf sticky", {31'd0, ovf_flag}, 32'd1);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule